// File: doc/BRIEF.md
# Dual-Clock Mailbox Register Pair

This block carries single words between two ports that run on unrelated clocks, alongside a data FIFO but without passing through it. Port A posts a word into mailbox 1, which port B collects; port B posts into mailbox 2, which port A collects. Each port has an active-low chip select, a write/read select (high writes), an enable and a mailbox select. With mailbox select high, an access is aimed at the mailbox; with it low, the port's read data comes from the FIFO output word supplied at the `*_fifo_q` input.

Each mailbox has two state machines. The writer machine has two states: `WR_IDLE` and `WR_PEND`. A write moves `WR_IDLE` to `WR_PEND` and flips a notify toggle. An acknowledge matching the toggle moves `WR_PEND` back to `WR_IDLE`. If a write lands in the same cycle as that acknowledge, the machine stays in `WR_PEND` and flips the toggle again. The reader machine has two states: `RD_EMPTY` and `RD_FULL`. A notify edge arriving through a two-flop synchronizer moves `RD_EMPTY` to `RD_FULL`. A mailbox read on the reader clock moves `RD_FULL` back to `RD_EMPTY` and flips an acknowledge toggle, which returns to the writer clock through another synchronizer. The reader's active-low full flag is low only in `RD_FULL`. The writer's pending output is high only in `WR_PEND`.

Top module: `mbx_pair`

## Requirements
- R1: After reset both full flags are high, both pending outputs are low and both mailboxes hold zero.
- R2: A port-A access with cs_n low, wr high, en high and mbx high loads a_din into mailbox 1 on the rising edge of a_clk; a port-B read with mbx high then presents that word on b_dout.
- R3: With a port's mbx input low, that port's dout equals its fifo_q input.
- R4: After a mailbox 1 write, b_mb1_full_n goes low within 8 b_clk cycles; it is never low while a_mb1_pend is low.
- R5: A port-B read (cs_n low, wr low, en high, mbx high) makes b_mb1_full_n high after that b_clk edge; the read leaves the mailbox contents unchanged, so a repeated read returns the same word.
- R6: A port-B access with en low, cs_n high or mbx low leaves b_mb1_full_n unchanged.
- R7: a_mb1_pend rises only on the edge of a mailbox 1 write, and falls within 10 a_clk cycles after the port-B read that consumed it.
- R8: A second write while mailbox 1 is still pending overwrites the word; the reader sees the newest word and the flag goes low only once.
- R9: Mailbox 2 behaves in the mirror direction: port-B writes, a_mb2_full_n, port-A reads and b_mb2_pend, with the same rules as R2 and R4 to R7.
- R10: A port-A access that is not a mailbox write (en low, cs_n high, wr low or mbx low) leaves mailbox 1 unchanged.
- R11: A port's dout_oe is high exactly when its cs_n is low and its wr is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| rst_n | input | 1 | Asynchronous active-low reset for both domains |
| a_clk | input | 1 | Port A clock |
| a_cs_n | input | 1 | Port A chip select, active low |
| a_wr | input | 1 | Port A write (1) or read (0) |
| a_en | input | 1 | Port A access enable |
| a_mbx | input | 1 | Port A mailbox select |
| a_din | input | DATA_W | Port A write data |
| a_fifo_q | input | DATA_W | FIFO word offered on port A reads |
| a_dout | output | DATA_W | Port A read data |
| a_dout_oe | output | 1 | Port A output enable |
| a_mb2_full_n | output | 1 | Mailbox 2 full flag, low when full |
| a_mb1_pend | output | 1 | Mailbox 1 written and not yet consumed |
| b_clk | input | 1 | Port B clock |
| b_cs_n | input | 1 | Port B chip select, active low |
| b_wr | input | 1 | Port B write (1) or read (0) |
| b_en | input | 1 | Port B access enable |
| b_mbx | input | 1 | Port B mailbox select |
| b_din | input | DATA_W | Port B write data |
| b_fifo_q | input | DATA_W | FIFO word offered on port B reads |
| b_dout | output | DATA_W | Port B read data |
| b_dout_oe | output | 1 | Port B output enable |
| b_mb1_full_n | output | 1 | Mailbox 1 full flag, low when full |
| b_mb2_pend | output | 1 | Mailbox 2 written and not yet consumed |

## Verification
The bench attacks the cases where the flag handshake is easy to break. A qualifier-stripped access must not clear the flag; a design that ignored en or mbx would empty the mailbox early. A read must not destroy data; a design that zeroed the word on read would return zero on the second read. Back-to-back writes must produce one notification carrying the newest word. A writer that toggled on every write could cancel its own notification, so the flag would never fall. A writer that ignored the overwrite would return stale data. The acknowledge path is also checked: the pending output must clear after a read, and a design whose acknowledge never matched the toggle would leave the writer pending forever.

// File: rtl/mbx_pkg.sv
package mbx_pkg;

    typedef enum logic {
        WR_IDLE = 1'b0,
        WR_PEND = 1'b1
    } wr_state_e;

    typedef enum logic {
        RD_EMPTY = 1'b0,
        RD_FULL  = 1'b1
    } rd_state_e;

endpackage

// File: rtl/mbx_sync.sv
module mbx_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic d,
    output logic q
);
    logic [STAGES-1:0] chain;

    generate
        for (genvar i = 0; i < STAGES; i++) begin : g_stage
            if (i == 0) begin : g_first
                always_ff @(posedge clk or negedge rst_n) begin
                    if (!rst_n) chain[0] <= 1'b0;
                    else        chain[0] <= d;
                end
            end else begin : g_next
                always_ff @(posedge clk or negedge rst_n) begin
                    if (!rst_n) chain[i] <= 1'b0;
                    else        chain[i] <= chain[i-1];
                end
            end
        end
    endgenerate

    assign q = chain[STAGES-1];
endmodule

// File: rtl/mbx_writer.sv
module mbx_writer
    import mbx_pkg::*;
#(
    parameter int DATA_W = 36
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_hit,
    input  logic [DATA_W-1:0] din,
    input  logic              ack_lvl,
    output logic [DATA_W-1:0] word_q,
    output logic              note_tgl,
    output logic              pend
);
    wr_state_e state_q, state_d;
    logic      flip;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q  <= WR_IDLE;
            note_tgl <= 1'b0;
        end else begin
            state_q  <= state_d;
            note_tgl <= note_tgl ^ flip;
        end
    end

    // data register: every write replaces the word
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)      word_q <= '0;
        else if (wr_hit) word_q <= din;
    end

    // next state and toggle request
    always_comb begin
        state_d = state_q;
        flip    = 1'b0;
        unique case (state_q)
            WR_IDLE: begin
                if (wr_hit) begin
                    state_d = WR_PEND;
                    flip    = 1'b1;
                end
            end
            WR_PEND: begin
                if (ack_lvl == note_tgl) begin
                    if (wr_hit) begin
                        state_d = WR_PEND;
                        flip    = 1'b1;
                    end else begin
                        state_d = WR_IDLE;
                    end
                end
            end
            default: state_d = WR_IDLE;
        endcase
    end

    // outputs
    always_comb begin
        pend = (state_q == WR_PEND);
    end
endmodule

// File: rtl/mbx_reader.sv
module mbx_reader
    import mbx_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic note_lvl,
    input  logic rd_hit,
    output logic full_n,
    output logic ack_tgl
);
    rd_state_e state_q, state_d;
    logic      seen_q;
    logic      note_evt;
    logic      flip;

    assign note_evt = note_lvl ^ seen_q;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= RD_EMPTY;
            seen_q  <= 1'b0;
            ack_tgl <= 1'b0;
        end else begin
            state_q <= state_d;
            seen_q  <= note_lvl;
            ack_tgl <= ack_tgl ^ flip;
        end
    end

    // next state
    always_comb begin
        state_d = state_q;
        flip    = 1'b0;
        unique case (state_q)
            RD_EMPTY: begin
                if (note_evt) state_d = RD_FULL;
            end
            RD_FULL: begin
                if (rd_hit) begin
                    state_d = RD_EMPTY;
                    flip    = 1'b1;
                end
            end
            default: state_d = RD_EMPTY;
        endcase
    end

    // outputs
    always_comb begin
        full_n = (state_q != RD_FULL);
    end
endmodule

// File: rtl/mbx_channel.sv
module mbx_channel #(
    parameter int DATA_W      = 36,
    parameter int SYNC_STAGES = 2
) (
    input  logic              rst_n,
    input  logic              wclk,
    input  logic              wr_hit,
    input  logic [DATA_W-1:0] din,
    output logic [DATA_W-1:0] word_q,
    output logic              pend,
    input  logic              rclk,
    input  logic              rd_hit,
    output logic              full_n
);
    logic note_tgl, note_r;
    logic ack_tgl, ack_w;

    mbx_writer #(.DATA_W(DATA_W)) u_wr (
        .clk      (wclk),
        .rst_n    (rst_n),
        .wr_hit   (wr_hit),
        .din      (din),
        .ack_lvl  (ack_w),
        .word_q   (word_q),
        .note_tgl (note_tgl),
        .pend     (pend)
    );

    mbx_sync #(.STAGES(SYNC_STAGES)) u_note_sync (
        .clk   (rclk),
        .rst_n (rst_n),
        .d     (note_tgl),
        .q     (note_r)
    );

    mbx_reader u_rd (
        .clk      (rclk),
        .rst_n    (rst_n),
        .note_lvl (note_r),
        .rd_hit   (rd_hit),
        .full_n   (full_n),
        .ack_tgl  (ack_tgl)
    );

    mbx_sync #(.STAGES(SYNC_STAGES)) u_ack_sync (
        .clk   (wclk),
        .rst_n (rst_n),
        .d     (ack_tgl),
        .q     (ack_w)
    );
endmodule

// File: rtl/mbx_pair.sv
module mbx_pair #(
    parameter int DATA_W      = 36,
    parameter int SYNC_STAGES = 2
) (
    input  logic              rst_n,
    input  logic              a_clk,
    input  logic              a_cs_n,
    input  logic              a_wr,
    input  logic              a_en,
    input  logic              a_mbx,
    input  logic [DATA_W-1:0] a_din,
    input  logic [DATA_W-1:0] a_fifo_q,
    output logic [DATA_W-1:0] a_dout,
    output logic              a_dout_oe,
    output logic              a_mb2_full_n,
    output logic              a_mb1_pend,
    input  logic              b_clk,
    input  logic              b_cs_n,
    input  logic              b_wr,
    input  logic              b_en,
    input  logic              b_mbx,
    input  logic [DATA_W-1:0] b_din,
    input  logic [DATA_W-1:0] b_fifo_q,
    output logic [DATA_W-1:0] b_dout,
    output logic              b_dout_oe,
    output logic              b_mb1_full_n,
    output logic              b_mb2_pend
);
    logic              a_acc, b_acc;
    logic              a_wr_hit, a_rd_hit, b_wr_hit, b_rd_hit;
    logic [DATA_W-1:0] mb1_q, mb2_q;

    // access decode
    assign a_acc    = !a_cs_n && a_en && a_mbx;
    assign b_acc    = !b_cs_n && b_en && b_mbx;
    assign a_wr_hit = a_acc && a_wr;
    assign a_rd_hit = a_acc && !a_wr;
    assign b_wr_hit = b_acc && b_wr;
    assign b_rd_hit = b_acc && !b_wr;

    // mailbox 1: A writes, B reads
    mbx_channel #(.DATA_W(DATA_W), .SYNC_STAGES(SYNC_STAGES)) u_mb1 (
        .rst_n  (rst_n),
        .wclk   (a_clk),
        .wr_hit (a_wr_hit),
        .din    (a_din),
        .word_q (mb1_q),
        .pend   (a_mb1_pend),
        .rclk   (b_clk),
        .rd_hit (b_rd_hit),
        .full_n (b_mb1_full_n)
    );

    // mailbox 2: B writes, A reads
    mbx_channel #(.DATA_W(DATA_W), .SYNC_STAGES(SYNC_STAGES)) u_mb2 (
        .rst_n  (rst_n),
        .wclk   (b_clk),
        .wr_hit (b_wr_hit),
        .din    (b_din),
        .word_q (mb2_q),
        .pend   (b_mb2_pend),
        .rclk   (a_clk),
        .rd_hit (a_rd_hit),
        .full_n (a_mb2_full_n)
    );

    // read data selection and output enables
    always_comb begin
        a_dout    = a_mbx ? mb2_q : a_fifo_q;
        b_dout    = b_mbx ? mb1_q : b_fifo_q;
        a_dout_oe = !a_cs_n && !a_wr;
        b_dout_oe = !b_cs_n && !b_wr;
    end
endmodule

// File: rtl/mbx_pair_checker.sv
module mbx_pair_checker #(
    parameter int DATA_W = 36
) (
    input logic              rst_n,
    input logic              a_clk,
    input logic              b_clk,
    input logic              a_wr_hit,
    input logic              a_rd_hit,
    input logic              b_wr_hit,
    input logic              b_rd_hit,
    input logic              a_mb1_pend,
    input logic              b_mb2_pend,
    input logic              a_mb2_full_n,
    input logic              b_mb1_full_n,
    input logic [DATA_W-1:0] mb1_q,
    input logic [DATA_W-1:0] mb2_q
);
    a_r5_read_empties_mb1: assert property (@(posedge b_clk) disable iff (!rst_n)
        b_rd_hit |=> b_mb1_full_n);

    a_r9_read_empties_mb2: assert property (@(posedge a_clk) disable iff (!rst_n)
        a_rd_hit |=> a_mb2_full_n);

    a_r4_full_needs_pend: assert property (@(posedge b_clk) disable iff (!rst_n)
        !b_mb1_full_n |-> a_mb1_pend);

    a_r9_full_needs_pend: assert property (@(posedge a_clk) disable iff (!rst_n)
        !a_mb2_full_n |-> b_mb2_pend);

    a_r7_pend_from_write: assert property (@(posedge a_clk) disable iff (!rst_n)
        $rose(a_mb1_pend) |-> $past(a_wr_hit));

    a_r9_pend_from_write: assert property (@(posedge b_clk) disable iff (!rst_n)
        $rose(b_mb2_pend) |-> $past(b_wr_hit));

    a_r10_mb1_holds: assert property (@(posedge a_clk) disable iff (!rst_n)
        !a_wr_hit |=> $stable(mb1_q));

    a_r5_mb2_holds: assert property (@(posedge b_clk) disable iff (!rst_n)
        !b_wr_hit |=> $stable(mb2_q));
endmodule

bind mbx_pair mbx_pair_checker #(.DATA_W(DATA_W)) u_chk (
    .rst_n        (rst_n),
    .a_clk        (a_clk),
    .b_clk        (b_clk),
    .a_wr_hit     (a_wr_hit),
    .a_rd_hit     (a_rd_hit),
    .b_wr_hit     (b_wr_hit),
    .b_rd_hit     (b_rd_hit),
    .a_mb1_pend   (a_mb1_pend),
    .b_mb2_pend   (b_mb2_pend),
    .a_mb2_full_n (a_mb2_full_n),
    .b_mb1_full_n (b_mb1_full_n),
    .mb1_q        (mb1_q),
    .mb2_q        (mb2_q)
);

// File: tb/mbx_pair_test.sv
module mbx_pair_test;
    localparam int W = 36;

    logic         rst_n = 1'b0;
    logic         a_clk = 1'b0, b_clk = 1'b0;
    logic         a_cs_n = 1'b1, a_wr = 1'b0, a_en = 1'b0, a_mbx = 1'b0;
    logic         b_cs_n = 1'b1, b_wr = 1'b0, b_en = 1'b0, b_mbx = 1'b0;
    logic [W-1:0] a_din = '0, a_fifo_q = '0, b_din = '0, b_fifo_q = '0;
    logic [W-1:0] a_dout, b_dout;
    logic         a_dout_oe, b_dout_oe, a_mb2_full_n, b_mb1_full_n, a_mb1_pend, b_mb2_pend;

    int checks = 0, errors = 0;
    logic [W-1:0] q1[$];
    logic [W-1:0] q2[$];

    always #2 a_clk = ~a_clk;   // 250 MHz
    always #7 b_clk = ~b_clk;

    mbx_pair #(.DATA_W(W)) uut (.*);

    task automatic chk(input string req, input logic [W-1:0] act, input logic [W-1:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic finish_run();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    endtask

    initial begin
        #800000;
        checks++; errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    // driver: port A mailbox write, expected word into the scoreboard
    task automatic a_write(input logic [W-1:0] d, input bit replace);
        @(negedge a_clk);
        a_cs_n = 0; a_wr = 1; a_en = 1; a_mbx = 1; a_din = d;
        @(negedge a_clk);
        a_cs_n = 1; a_wr = 0; a_en = 0;
        if (replace && q1.size() > 0) void'(q1.pop_back());
        q1.push_back(d);
    endtask

    task automatic b_write(input logic [W-1:0] d);
        @(negedge b_clk);
        b_cs_n = 0; b_wr = 1; b_en = 1; b_mbx = 1; b_din = d;
        @(negedge b_clk);
        b_cs_n = 1; b_wr = 0; b_en = 0;
        q2.push_back(d);
    endtask

    // monitor: port B mailbox read, compared against scoreboard
    task automatic b_read(input string req, input bit pop);
        logic [W-1:0] exp;
        @(negedge b_clk);
        b_cs_n = 0; b_wr = 0; b_en = 1; b_mbx = 1;
        #1;
        exp = (q1.size() > 0) ? q1[0] : '0;
        if (pop && q1.size() > 0) void'(q1.pop_front());
        chk(req, b_dout, exp);
        @(negedge b_clk);
        b_cs_n = 1; b_en = 0;
        chk("R5 flag high after read", b_mb1_full_n, 1);
    endtask

    task automatic a_read(input string req);
        logic [W-1:0] exp;
        @(negedge a_clk);
        a_cs_n = 0; a_wr = 0; a_en = 1; a_mbx = 1;
        #1;
        exp = (q2.size() > 0) ? q2.pop_front() : '0;
        chk(req, a_dout, exp);
        @(negedge a_clk);
        a_cs_n = 1; a_en = 0;
        chk("R9 a flag high after read", a_mb2_full_n, 1);
    endtask

    task automatic wait_b_full(input string req);
        int n = 0;
        while (b_mb1_full_n && n < 8) begin @(negedge b_clk); n++; end
        chk(req, b_mb1_full_n, 0);
    endtask

    task automatic wait_a_full(input string req);
        int n = 0;
        while (a_mb2_full_n && n < 8) begin @(negedge a_clk); n++; end
        chk(req, a_mb2_full_n, 0);
    endtask

    task automatic wait_a_idle(input string req);
        int n = 0;
        while (a_mb1_pend && n < 10) begin @(negedge a_clk); n++; end
        chk(req, a_mb1_pend, 0);
    endtask

    initial begin
        repeat (3) @(negedge b_clk);
        rst_n = 1;
        @(negedge b_clk);
        // R1 reset state
        chk("R1 b flag", b_mb1_full_n, 1);
        chk("R1 a flag", a_mb2_full_n, 1);
        chk("R1 a pend", a_mb1_pend, 0);
        chk("R1 b pend", b_mb2_pend, 0);
        b_mbx = 1; a_mbx = 1; #1;
        chk("R1 mb1 zero", b_dout, '0);
        chk("R1 mb2 zero", a_dout, '0);
        // R3 FIFO path
        b_mbx = 0; b_fifo_q = 36'h9_1234_5678; a_mbx = 0; a_fifo_q = 36'h5_A5A5_0F0F; #1;
        chk("R3 b fifo path", b_dout, 36'h9_1234_5678);
        chk("R3 a fifo path", a_dout, 36'h5_A5A5_0F0F);
        // R11 output enable
        b_cs_n = 0; b_wr = 0; #1; chk("R11 oe on", b_dout_oe, 1);
        b_wr = 1; #1; chk("R11 oe off wr", b_dout_oe, 0);
        b_wr = 0; b_cs_n = 1; #1; chk("R11 oe off cs", b_dout_oe, 0);
        a_cs_n = 0; #1; chk("R11 a oe on", a_dout_oe, 1);
        a_cs_n = 1; b_mbx = 1; a_mbx = 0;

        // R10 non-write accesses leave mailbox 1 alone
        @(negedge a_clk);
        a_din = 36'hF_FFFF_FFFF; a_wr = 1; a_mbx = 1; a_cs_n = 0; a_en = 0;
        @(negedge a_clk); a_en = 1; a_cs_n = 1;
        @(negedge a_clk); a_cs_n = 0; a_mbx = 0;
        @(negedge a_clk); a_mbx = 1; a_wr = 0;
        @(negedge a_clk); a_cs_n = 1; a_en = 0;
        repeat (6) @(negedge b_clk);
        #1; chk("R10 mb1 unchanged", b_dout, '0);
        chk("R10 no flag", b_mb1_full_n, 1);
        chk("R10 no pend", a_mb1_pend, 0);

        // R2/R4/R5/R7 basic transfer
        a_write(36'hC_0FFE_E123, 0);
        chk("R7 pend after write", a_mb1_pend, 1);
        wait_b_full("R4 flag low after write");
        b_read("R2 word delivered", 0);
        b_read("R5 non-destructive reread", 1);
        wait_a_idle("R7 pend clears");

        // R6 disqualified reads do not clear
        a_write(36'h3_1415_9265, 0);
        wait_b_full("R4 flag low second write");
        @(negedge b_clk); b_cs_n = 0; b_wr = 0; b_en = 0; b_mbx = 1;
        @(negedge b_clk); b_en = 1; b_cs_n = 1;
        @(negedge b_clk); b_cs_n = 0; b_mbx = 0;
        @(negedge b_clk); b_cs_n = 1; b_en = 0; b_mbx = 1;
        chk("R6 flag held", b_mb1_full_n, 0);
        chk("R6 still pend", a_mb1_pend, 1);
        b_read("R6 word after ignored reads", 1);
        wait_a_idle("R7 pend clears again");

        // R8 overwrite while pending
        a_write(36'h1_1111_1111, 0);
        a_write(36'h2_2222_2222, 1);
        wait_b_full("R8 flag low");
        b_read("R8 newest word", 1);
        repeat (8) @(negedge b_clk);
        chk("R8 single event", b_mb1_full_n, 1);
        wait_a_idle("R8 pend clears");

        // R9 mirror direction
        b_write(36'hE_DCBA_9876);
        chk("R9 b pend", b_mb2_pend, 1);
        wait_a_full("R9 a flag low");
        a_read("R9 word at port A");
        begin
            int n = 0;
            while (b_mb2_pend && n < 10) begin @(negedge b_clk); n++; end
            chk("R9 b pend clears", b_mb2_pend, 0);
        end
        finish_run();
    end
endmodule